// File: doc/BRIEF.md
# Serial Channel-Select Controller with Break-Before-Make

This block is the digital control logic for an eight-way switch that is set up through a serial port. While the chip-select input is high, a four-bit shift register takes one bit from the primary data pin on every rising clock edge. The word is an enable bit, sent first, followed by a three-bit channel address, sent most significant bit first.

The word takes effect only when chip select falls. At that edge every channel enable is dropped at once. After a settling delay of a parameterised number of clock cycles, the addressed channel's enable is raised if the enable bit is 1. If the enable bit is 0, all channels stay off. The chosen channel stays on until the next falling edge of chip select, even while a new word is being shifted in.

The two data pins are bidirectional. Each pin is modelled as a separate input, output and output-enable. With chip select high, the secondary pin drives out the bit at the top of the register, so several controllers can be chained. With chip select low, the primary pin drives back whatever arrives on the secondary pin.

Top module: `chsel_serial_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the shift register, turns all eight channel enables and the active flag off, and leaves both data outputs undriven (both output-enables 0).
- R2: While chip select is high, each rising clock edge shifts the primary data input into bit 0 of the register. After four edges, bit 3 holds the first bit sent (the enable bit) and bits 2..0 hold the channel address, sent in the order B2, B1, B0.
- R3: While chip select is low, the register keeps its contents whatever the primary data input does.
- R4: The first rising edge that samples chip select low after it was high drives all eight channel enables and the active flag to 0.
- R5: ON_DELAY rising edges after the edge in R4 (default 2), channel enable bit N goes to 1, where N is the committed address, if the committed enable bit is 1. If the enable bit is 0, all channel enables stay 0. The active flag is 1 exactly when a channel enable is 1.
- R6: Once set, the channel enables do not change until the next falling edge of chip select, including while chip select is high and bits are being shifted.
- R7: With chip select high, the secondary output is enabled and the primary output is not. With chip select low, after chip select has been high at least once since reset, the primary output is enabled and carries the secondary input, and the secondary output is not enabled. The two output-enables are never both 1.
- R8: A new falling edge of chip select during the settling delay forces all enables off again, commits the register contents at that moment and restarts the full ON_DELAY count.
- R9: The channel enables come from registers and are always one-hot or all zero.
- R10: While chip select is high, the secondary data output equals register bit 3, which is the primary input bit sampled four shifting edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select: high to shift, falling edge to commit |
| pri_in_i | input | 1 | Primary data pin, input side (serial word in) |
| pri_out_o | output | 1 | Primary data pin, output side (return path) |
| pri_oe_o | output | 1 | Primary data pin output-enable |
| sec_in_i | input | 1 | Secondary data pin, input side |
| sec_out_o | output | 1 | Secondary data pin, output side (chain output) |
| sec_oe_o | output | 1 | Secondary data pin output-enable |
| ch_en_o | output | 8 | Channel enables, one-hot or all zero |
| active_o | output | 1 | High while a channel is enabled |

## Verification
The assertions assume that chip select and both data inputs are synchronous to the clock and hold a known value at every rising edge after reset. No gap between edges of chip select is assumed. The stimulus changes every input only on the falling clock edge and never leaves one undriven. It starts chip select low, so the first edge seen after reset is a clean rising one. It also produces the short chip-select pulses that the restart rule needs.

// File: rtl/chsel_pkg.sv
// Package chsel_pkg
// Shared types for the serial channel-select controller.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package chsel_pkg;

    // Phases of the enable sequencer.
    typedef enum logic [0:0] {
        SEQ_HOLD  = 1'b0,   // outputs steady, waiting for a commit
        SEQ_BREAK = 1'b1    // all channels off, settling count running
    } seq_state_e;

    // A committed control word split into its fields.
    typedef struct packed {
        logic       en;     // channel enable bit
        logic [2:0] sel;    // channel address
    } ctrl_word_t;

endpackage

// File: rtl/chsel_shift_reg.sv
// Module chsel_shift_reg
// Serial-in shift register. It moves in one bit per enabled clock and
// exposes the whole word plus the bit at its top end for chaining.
// Assumes shift_en and din are synchronous to clk.
module chsel_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word_o,
    output logic             msb_o
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] sr_q;

    // Shift toward the top end on every enabled edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= {sr_q[TOP-1:0], din};
    end

    assign word_o = sr_q;
    assign msb_o  = sr_q[TOP];

    // R3: no shift while chip select is low.
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));

    // R2: a shift moves the old low bits up by one place.
    assert_shift_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[TOP:1] == $past(sr_q[TOP-1:0]));

endmodule

// File: rtl/chsel_port_dir.sv
// Module chsel_port_dir
// Steers the two bidirectional data pins by chip select. It leaves both
// pins undriven from reset until chip select has been high once.
// Assumes cs is synchronous to clk.
module chsel_port_dir (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic chain_bit,
    input  logic sec_in,
    output logic pri_out,
    output logic pri_oe,
    output logic sec_out,
    output logic sec_oe
);

    logic seen_q;

    // Note that chip select has been asserted at least once since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (cs)
            seen_q <= 1'b1;
    end

    // Choose the driving direction from chip select.
    always_comb begin
        sec_oe  = rst_n & cs;
        sec_out = chain_bit;
        pri_oe  = rst_n & ~cs & seen_q;
        pri_out = sec_in;
    end

    // R7: never drive both pins at once.
    assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_oe && sec_oe));

    // R1: no return path before chip select has been high.
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pri_oe);

endmodule

// File: rtl/chsel_seq.sv
// Module chsel_seq
// Break-before-make sequencer. It finds the falling edge of chip select,
// commits the shifted word, holds every channel off for ON_DELAY cycles
// and then raises the one-hot enable of the addressed channel.
// Assumes ON_DELAY >= 1 and that cs is synchronous to clk.
module chsel_seq
    import chsel_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SEL_W    = 3,
    parameter int ON_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic [SEL_W:0]   word,
    output logic [NCH-1:0]   ch_en_o,
    output logic             active_o
);

    localparam int                CNT_W = $clog2(ON_DELAY + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(ON_DELAY - 1);

    seq_state_e      state_q;
    logic            cs_q;
    logic            cs_fall;
    logic [CNT_W-1:0] cnt_q;
    logic            en_q;
    logic [SEL_W-1:0] sel_q;
    logic [NCH-1:0]  dec;
    logic [NCH-1:0]  ch_en_q;
    logic            active_q;

    // Keep last cycle's chip select to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= 1'b0;
        else
            cs_q <= cs;
    end

    assign cs_fall = cs_q & ~cs;

    // Address decoder, one compare per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign dec[g] = en_q && (sel_q == SEL_W'(g));
    end

    // Sequence commit, break interval and turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_HOLD;
            cnt_q    <= '0;
            en_q     <= 1'b0;
            sel_q    <= '0;
            ch_en_q  <= '0;
            active_q <= 1'b0;
        end else if (cs_fall) begin
            state_q  <= SEQ_BREAK;
            cnt_q    <= '0;
            en_q     <= word[SEL_W];
            sel_q    <= word[SEL_W-1:0];
            ch_en_q  <= '0;
            active_q <= 1'b0;
        end else if (state_q == SEQ_BREAK) begin
            if (cnt_q == LAST) begin
                state_q  <= SEQ_HOLD;
                ch_en_q  <= dec;
                active_q <= en_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ch_en_o  = ch_en_q;
    assign active_o = active_q;

    // R9: enables are one-hot or all zero.
    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en_q));

    // R4: a commit turns every channel off on the next edge.
    assert_break_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (ch_en_q == '0) && !active_q);

    // R6: enables stay put outside a commit and the break interval.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HOLD) && !cs_fall |=> $stable(ch_en_q));

    // R5: the active flag follows whether a channel is on.
    assert_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q == (ch_en_q != '0));

    // R8: the settling count never runs past its limit.
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/chsel_serial_ctrl.sv
// Module chsel_serial_ctrl
// Top of the serial channel-select controller: shift register, pin
// direction steering and the break-before-make sequencer.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module chsel_serial_ctrl
    import chsel_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int ON_DELAY = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_i,
    input  logic           pri_in_i,
    output logic           pri_out_o,
    output logic           pri_oe_o,
    input  logic           sec_in_i,
    output logic           sec_out_o,
    output logic           sec_oe_o,
    output logic [NCH-1:0] ch_en_o,
    output logic           active_o
);

    localparam int SEL_W  = $clog2(NCH);
    localparam int WORD_W = SEL_W + 1;

    logic [WORD_W-1:0] word;
    logic              msb;

    chsel_shift_reg #(.WIDTH(WORD_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cs_i),
        .din      (pri_in_i),
        .word_o   (word),
        .msb_o    (msb)
    );

    chsel_port_dir u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs_i),
        .chain_bit (msb),
        .sec_in    (sec_in_i),
        .pri_out   (pri_out_o),
        .pri_oe    (pri_oe_o),
        .sec_out   (sec_out_o),
        .sec_oe    (sec_oe_o)
    );

    chsel_seq #(
        .NCH      (NCH),
        .SEL_W    (SEL_W),
        .ON_DELAY (ON_DELAY)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs_i),
        .word     (word),
        .ch_en_o  (ch_en_o),
        .active_o (active_o)
    );

endmodule

// File: tb/chsel_serial_ctrl_tb.sv
// Bench for chsel_serial_ctrl: a vector table walk, then directed tests.
module chsel_serial_ctrl_tb_top;

    localparam int DLY = 2;
    localparam int NV  = 6;
    // {control word, expected enables}; word = {EN, B2, B1, B0}
    localparam logic [11:0] VEC [NV] = '{
        {4'h8, 8'h01}, {4'hA, 8'h04}, {4'hF, 8'h80},
        {4'h3, 8'h00}, {4'hD, 8'h20}, {4'hE, 8'h40}
    };

    logic clk = 1'b0;
    logic rst_n, cs, pri_in, sec_in;
    logic pri_out, pri_oe, sec_out, sec_oe, active;
    logic [7:0] ch_en;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chsel_serial_ctrl #(.NCH(8), .ON_DELAY(DLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .pri_in_i(pri_in),
        .pri_out_o(pri_out), .pri_oe_o(pri_oe), .sec_in_i(sec_in),
        .sec_out_o(sec_out), .sec_oe_o(sec_oe), .ch_en_o(ch_en),
        .active_o(active)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Shift a 4-bit word with chip select high, first bit = word[3].
    task automatic send(input logic [3:0] w);
        for (int i = 3; i >= 0; i--) begin
            cs = 1'b1; pri_in = w[i];
            tick();
        end
    endtask

    // Drop chip select, then check break and turn-on timing.
    task automatic commit(input logic [7:0] exp);
        cs = 1'b0;
        tick();
        chk(ch_en == 8'h00 && !active, "R4 break", ch_en, 0);
        for (int k = 1; k < DLY; k++) begin
            tick();
            chk(ch_en == 8'h00, "R5 still off in delay", ch_en, 0);
        end
        tick();
        chk(ch_en == exp, "R5 enable after delay", ch_en, exp);
        chk(active == (exp != 0), "R5 active flag", active, exp != 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] bits;
        rst_n = 1'b0; cs = 1'b0; pri_in = 1'b0; sec_in = 1'b0;
        repeat (3) tick();
        chk(ch_en == 0 && !active, "R1 enables off", ch_en, 0);
        chk(!pri_oe && !sec_oe, "R1 pins undriven", {pri_oe, sec_oe}, 0);
        rst_n = 1'b1;
        tick();
        chk(!pri_oe && !sec_oe, "R7 undriven before first cs", {pri_oe, sec_oe}, 0);

        // Table walk: R2 word order, R10 chain bit, R4/R5 commit timing.
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][11:8]);
            chk(sec_oe && !pri_oe, "R7 cs high direction", {pri_oe, sec_oe}, 1);
            chk(sec_out == VEC[v][11], "R2 enable bit on top", sec_out, VEC[v][11]);
            commit(VEC[v][7:0]);
        end

        // R6: enable 0x40 held while a new word is shifted.
        for (int i = 0; i < 4; i++) begin
            cs = 1'b1; pri_in = i[0];
            tick();
            chk(ch_en == 8'h40, "R6 hold while shifting", ch_en, 8'h40);
        end
        // register now 0101 -> EN=0
        commit(8'h00);

        // R7 return path and R3 freeze with cs low.
        send(4'hB);
        commit(8'h08);
        for (int i = 0; i < 3; i++) begin
            pri_in = ~pri_in; sec_in = i[0];
            #1;
            chk(pri_oe && !sec_oe, "R7 cs low direction", {pri_oe, sec_oe}, 2);
            chk(pri_out == sec_in, "R7 return data", pri_out, sec_in);
            tick();
        end
        cs = 1'b1; #1;
        chk(sec_out == 1'b1, "R3 register frozen while cs low", sec_out, 1);
        @(negedge clk);

        // R10: chain output lags the serial input by four shifts.
        bits = 8'b1011_0010;
        for (int j = 0; j < 8; j++) begin
            cs = 1'b1; pri_in = bits[7-j];
            tick();
            if (j >= 3)
                chk(sec_out == bits[7-(j-3)], "R10 chain delay", sec_out, bits[7-(j-3)]);
        end
        // register = 0010 -> EN=0
        commit(8'h00);

        // R8: restart of the break on a second fall during the delay.
        send(4'hF);
        cs = 1'b0;
        tick();
        chk(ch_en == 0, "R8 first break", ch_en, 0);
        cs = 1'b1; pri_in = 1'b1;
        tick();
        cs = 1'b0;
        tick();
        chk(ch_en == 0, "R8 restart keeps off", ch_en, 0);
        tick();
        chk(ch_en == 0, "R8 count restarted", ch_en, 0);
        tick();
        chk(ch_en == 8'h80, "R8 enable after full delay", ch_en, 8'h80);
        chk(((ch_en & (ch_en - 1)) == 0), "R9 one-hot", ch_en, 8'h80);

        // R1: reset in the middle of operation.
        rst_n = 1'b0;
        tick();
        chk(ch_en == 0 && !active, "R1 reset clears enables", ch_en, 0);
        chk(!pri_oe && !sec_oe, "R1 reset pins", {pri_oe, sec_oe}, 0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule